// File: doc/BRIEF.md
# Branch Target Validation Cache

This block caches branch target addresses that an external checker has already confirmed to be the start of a real instruction. Without it, every such check would need the slow path. Each lookup presents a target address. One cycle later the block answers with hit, meaning the target is known good, or miss. On a miss the outside validator resolves the target by its own means. If the target is legal, the validator writes it back through the fill port, so the next jump to it hits.

Storage is set-associative: `SETS` sets of `WAYS` entries each. Each entry is either empty or holds the full target address. The set is picked by the low address bits, and all ways of that set are compared in parallel. Replacement within a set uses a tree pseudo-LRU.

A mode input lets direct transfers skip the check entirely, which is safe when code pages cannot be written. A flush input empties the cache on a context switch.

Top module: `tgt_valid_cache`

## Requirements
- R1: After reset `rsp_valid_o` and `rsp_hit_o` are 0 and every entry is empty, so a checked lookup of any address misses.
- R2: A lookup presented with `lk_valid_i` high gets its answer on `rsp_valid_o`/`rsp_hit_o` exactly one cycle later. A new lookup may be issued every cycle. `rsp_hit_o` is never high while `rsp_valid_o` is low.
- R3: The set index is `addr[IDX_W-1:0]` (IDX_W = log2 SETS). A checked lookup hits only if a valid entry of that set holds the same upper bits `addr[ADDR_W-1:IDX_W]`. A different tag in the same set, or the same tag in another set, misses.
- R4: A fill stores the address so that later lookups of it hit. A lookup in the same cycle as a fill sees the contents from before the fill.
- R5: A fill of an absent address writes the lowest-numbered empty way of its set when one exists.
- R6: When the set is full, the fill replaces the pseudo-LRU victim. The tree has nodes 1..WAYS-1, where node n has children 2n and 2n+1 and its bit is stored at index n-1. The victim walk starts at node 1 and goes to child 2n+bit. The leaf node L names way L-WAYS.
- R7: A checked hit and every fill touch the way used. Touching walks from the root along the way number's bits, MSB first, and sets each visited node's bit to the inverse of the direction taken. A hit and a fill in the same cycle apply the hit touch first, and the fill's victim is taken after it.
- R8: Filling an address already present only touches the existing way; no set ever holds the same address twice.
- R9: `flush_i` empties every entry in one cycle (pseudo-LRU bits are kept). A checked lookup in the flush cycle reports miss, and a fill in the flush cycle is dropped.
- R10: With `ind_only_i` high, a lookup with `lk_indirect_i` low is not checked. It reports hit and touches nothing. With `ind_only_i` low, every lookup is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty all entries |
| ind_only_i | input | 1 | Check only indirect transfers |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_addr_i | input | ADDR_W | Target address to check |
| lk_indirect_i | input | 1 | Lookup comes from an indirect transfer |
| fill_valid_i | input | 1 | Insert a validated address |
| fill_addr_i | input | ADDR_W | Address to insert |
| rsp_valid_o | output | 1 | Lookup answer valid |
| rsp_hit_o | output | 1 | Target known valid (1) or miss (0) |

## Verification
Several rules are checked on every cycle:
- A set never holds duplicate addresses.
- A filled address is resident one cycle later.
- A flush leaves every entry empty.
- Flush-cycle checked lookups miss and bypassed lookups hit.
- Empty ways are preferred over the victim.

Exact victim choice across long hit/fill histories can only be shown by the bench. It compares every answer against a reference model of the pseudo-LRU tree. So can the pre-fill view of same-cycle lookups, and the ordering of a hit and a fill landing on the same set.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
  typedef enum logic [1:0] {
    FA_NONE  = 2'd0,
    FA_TOUCH = 2'd1,
    FA_WRITE = 2'd2
  } fill_act_e;
endpackage

// File: rtl/tvc_match.sv
module tvc_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 25,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        any_hit,
  output logic [WAY_W-1:0]            hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld[w] && (tags[w] == key);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tvc_plru.sv
module tvc_plru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  bits_in,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAYS-2:0]  bits_out,
  output logic [WAY_W-1:0] victim
);
  always_comb begin
    int node;
    bits_out = bits_in;
    node = 1;
    if (touch_en) begin
      for (int lvl = WAY_W - 1; lvl >= 0; lvl--) begin
        bits_out[node-1] = ~touch_way[lvl];
        node = 2 * node + int'(touch_way[lvl]);
      end
    end
  end

  always_comb begin
    int node;
    node = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      node = 2 * node + int'(bits_in[node-1]);
    end
    victim = WAY_W'(node - WAYS);
  end
endmodule

// File: rtl/tvc_fill_pick.sv
module tvc_fill_pick
  import tvc_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             fill_req,
  input  logic [WAYS-1:0]  vld,
  input  logic             present,
  input  logic [WAY_W-1:0] present_way,
  input  logic [WAY_W-1:0] victim,
  output fill_act_e        act,
  output logic [WAY_W-1:0] way
);
  logic             has_free;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    act = FA_NONE;
    way = '0;
    if (fill_req) begin
      if (present) begin
        act = FA_TOUCH;
        way = present_way;
      end else begin
        act = FA_WRITE;
        way = has_free ? free_way : victim;
      end
    end
  end
endmodule

// File: rtl/tgt_valid_cache.sv
module tgt_valid_cache
  import tvc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              ind_only_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              lk_indirect_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o
);
  logic [SETS-1:0][WAYS-1:0] vld_q, vld_d;
  logic [SETS-1:0][WAYS-2:0] plru_q, plru_d;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic                      vld_en, plru_en, tag_we;
  logic                      rsp_valid_d, rsp_hit_d;

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_set = lk_addr_i[IDX_W-1:0];
  assign lk_tag = lk_addr_i[ADDR_W-1:IDX_W];
  assign fl_set = fill_addr_i[IDX_W-1:0];
  assign fl_tag = fill_addr_i[ADDR_W-1:IDX_W];

  logic [WAYS-1:0][TAG_W-1:0] lk_tags, fl_tags;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_tags[w] = tag_q[lk_set][w];
      fl_tags[w] = tag_q[fl_set][w];
    end
  end

  logic [WAYS-1:0]  lk_hit_vec, fl_hit_vec;
  logic             lk_any, fl_any;
  logic [WAY_W-1:0] lk_way, fl_way_hit;

  tvc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .vld(vld_q[lk_set]), .tags(lk_tags), .key(lk_tag),
    .hit_vec(lk_hit_vec), .any_hit(lk_any), .hit_way(lk_way));

  tvc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .vld(vld_q[fl_set]), .tags(fl_tags), .key(fl_tag),
    .hit_vec(fl_hit_vec), .any_hit(fl_any), .hit_way(fl_way_hit));

  logic checked, hit_touch, fill_req;
  assign checked   = !(ind_only_i && !lk_indirect_i);
  assign hit_touch = lk_valid_i && checked && lk_any && !flush_i;
  assign fill_req  = fill_valid_i && !flush_i;

  logic [WAYS-2:0]  hit_bits, fill_bits_in, fill_bits;
  logic [WAY_W-1:0] hit_victim, fill_victim, fill_way;
  fill_act_e        fill_act;

  tvc_plru #(.WAYS(WAYS)) u_plru_hit (
    .bits_in(plru_q[lk_set]), .touch_en(hit_touch), .touch_way(lk_way),
    .bits_out(hit_bits), .victim(hit_victim));

  assign fill_bits_in = (hit_touch && (lk_set == fl_set)) ? hit_bits : plru_q[fl_set];

  tvc_fill_pick #(.WAYS(WAYS)) u_pick (
    .fill_req(fill_req), .vld(vld_q[fl_set]), .present(fl_any),
    .present_way(fl_way_hit), .victim(fill_victim), .act(fill_act), .way(fill_way));

  tvc_plru #(.WAYS(WAYS)) u_plru_fill (
    .bits_in(fill_bits_in), .touch_en(fill_act != FA_NONE), .touch_way(fill_way),
    .bits_out(fill_bits), .victim(fill_victim));

  // next state
  always_comb begin
    tag_we      = (fill_act == FA_WRITE);
    vld_en      = flush_i || tag_we;
    plru_en     = hit_touch || (fill_act != FA_NONE);
    vld_d       = vld_q;
    plru_d      = plru_q;
    rsp_valid_d = lk_valid_i;
    rsp_hit_d   = lk_valid_i && (!checked || (lk_any && !flush_i));
    if (flush_i)     vld_d = '0;
    else if (tag_we) vld_d[fl_set][fill_way] = 1'b1;
    if (hit_touch)   plru_d[lk_set] = hit_bits;
    if (fill_act != FA_NONE) plru_d[fl_set] = fill_bits;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= '0;
      plru_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
    end else begin
      if (vld_en)  vld_q  <= vld_d;
      if (plru_en) plru_q <= plru_d;
      rsp_valid_o <= rsp_valid_d;
      rsp_hit_o   <= rsp_hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[fl_set][fill_way] <= fl_tag;
  end

  function automatic logic resident(input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[a[IDX_W-1:0]][w] && tag_q[a[IDX_W-1:0]][w] == a[ADDR_W-1:IDX_W]) r = 1'b1;
    end
    return r;
  endfunction

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit_o |-> rsp_valid_o); // R2
  AST_SET_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec) && $onehot0(fl_hit_vec)); // R8
  AST_FILL_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && !flush_i) |=> resident($past(fill_addr_i))); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0)); // R9
  AST_FLUSH_LOOKUP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && lk_valid_i && checked) |=> !rsp_hit_o); // R9
  AST_BYPASS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && ind_only_i && !lk_indirect_i) |=> rsp_hit_o); // R10
  AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_act == FA_WRITE && !(&vld_q[fl_set])) |-> !vld_q[fl_set][fill_way]); // R5
endmodule

// File: tb/tgt_valid_cache_tb_top.sv
module tgt_valid_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int SETS   = 128;
  localparam int WAYS   = 4;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0, ind_only_i = 1'b0, lk_valid_i = 1'b0, lk_indirect_i = 1'b0;
  logic fill_valid_i = 1'b0;
  logic [ADDR_W-1:0] lk_addr_i = '0, fill_addr_i = '0;
  logic rsp_valid_o, rsp_hit_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgt_valid_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .ind_only_i(ind_only_i),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_indirect_i(lk_indirect_i),
    .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o));

  // reference model
  bit                  m_vld [SETS][WAYS];
  logic [ADDR_W-1:0]   m_adr [SETS][WAYS];
  bit [WAYS-2:0]       m_tree [SETS];

  function automatic int m_find(logic [ADDR_W-1:0] a);
    int s = int'(a[IDX_W-1:0]);
    for (int w = 0; w < WAYS; w++) if (m_vld[s][w] && m_adr[s][w] == a) return w;
    return -1;
  endfunction

  function automatic void m_touch(int s, int w);
    int n = 1;
    for (int l = WAY_W - 1; l >= 0; l--) begin
      int d = (w >> l) & 1;
      m_tree[s][n-1] = (d == 0);
      n = 2 * n + d;
    end
  endfunction

  function automatic int m_victim(int s);
    int n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + int'(m_tree[s][n-1]);
    return n - WAYS;
  endfunction

  bit exp_valid, exp_hit;

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one cycle, predict, then compare the registered answer
  task automatic cyc(input bit lv, input logic [ADDR_W-1:0] la, input bit li, input bit mode,
                     input bit fv, input logic [ADDR_W-1:0] fa, input bit fl, input string req);
    bit chkd;
    int hw, s, fs, fw;
    chkd = !(mode && !li);
    hw = m_find(la);
    exp_valid = lv;
    exp_hit = lv && (!chkd || (hw >= 0 && !fl));
    if (lv && chkd && hw >= 0 && !fl) begin
      s = int'(la[IDX_W-1:0]);
      m_touch(s, hw);
    end
    if (fl) begin
      for (int i = 0; i < SETS; i++) for (int w = 0; w < WAYS; w++) m_vld[i][w] = 1'b0;
    end else if (fv) begin
      fs = int'(fa[IDX_W-1:0]);
      fw = m_find(fa);
      if (fw < 0) begin
        fw = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[fs][w]) fw = w;
        if (fw < 0) fw = m_victim(fs);
        m_vld[fs][fw] = 1'b1;
        m_adr[fs][fw] = fa;
      end
      m_touch(fs, fw);
    end
    lk_valid_i = lv; lk_addr_i = la; lk_indirect_i = li; ind_only_i = mode;
    fill_valid_i = fv; fill_addr_i = fa; flush_i = fl;
    @(posedge clk); #1;
    chk(rsp_valid_o == exp_valid, "R2", "rsp_valid", int'(rsp_valid_o), int'(exp_valid));
    chk(rsp_hit_o == exp_hit, req, "rsp_hit", int'(rsp_hit_o), int'(exp_hit));
  endtask

  function automatic logic [ADDR_W-1:0] mk(int tag, int idx);
    return {(ADDR_W-IDX_W)'(tag), IDX_W'(idx)};
  endfunction

  task automatic look(input logic [ADDR_W-1:0] a, input bit hard_exp, input string req);
    cyc(1, a, 1, 0, 0, '0, 0, req);
    chk(rsp_hit_o == hard_exp, req, "directed hit", int'(rsp_hit_o), int'(hard_exp));
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a, input string req);
    cyc(0, '0, 0, 0, 1, a, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < SETS; i++) begin
      m_tree[i] = '0;
      for (int w = 0; w < WAYS; w++) begin m_vld[i][w] = 1'b0; m_adr[i][w] = '0; end
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(rsp_valid_o == 1'b0, "R1", "reset rsp_valid", int'(rsp_valid_o), 0);
    chk(rsp_hit_o == 1'b0, "R1", "reset rsp_hit", int'(rsp_hit_o), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    look(mk(0, 0), 0, "R1");
    // R3/R4 basic fill then hit, aliasing misses
    fill(mk(7, 3), "R4");
    look(mk(7, 3), 1, "R3");
    look(mk(8, 3), 0, "R3");
    look(mk(7, 4), 0, "R3");
    // R4 same-cycle lookup sees pre-fill contents
    cyc(1, mk(9, 3), 1, 0, 1, mk(9, 3), 0, "R4");
    chk(rsp_hit_o == 1'b0, "R4", "pre-fill view", int'(rsp_hit_o), 0);
    look(mk(9, 3), 1, "R4");
    // R5/R6 fill a set of 4 in order then evict way 0 (first-filled)
    fill(mk(1, 5), "R5"); fill(mk(2, 5), "R5"); fill(mk(3, 5), "R5"); fill(mk(4, 5), "R5");
    fill(mk(5, 5), "R6");
    look(mk(1, 5), 0, "R6");
    look(mk(2, 5), 1, "R6");
    // R8 refill of a present address: no duplicate, then victim follows touch
    fill(mk(2, 5), "R8");
    look(mk(2, 5), 1, "R8");
    // R7 hit and fill same set same cycle
    cyc(1, mk(3, 5), 1, 0, 1, mk(6, 5), 0, "R7");
    look(mk(3, 5), 1, "R7");
    look(mk(6, 5), 1, "R7");
    // R10 bypass and checked direct
    cyc(1, mk(99, 9), 0, 1, 0, '0, 0, "R10");
    chk(rsp_hit_o == 1'b1, "R10", "bypass hit", int'(rsp_hit_o), 1);
    cyc(1, mk(99, 9), 0, 0, 0, '0, 0, "R10");
    chk(rsp_hit_o == 1'b0, "R10", "checked direct", int'(rsp_hit_o), 0);
    // R9 flush with lookup and fill in the same cycle
    cyc(1, mk(7, 3), 1, 0, 1, mk(11, 2), 1, "R9");
    chk(rsp_hit_o == 1'b0, "R9", "flush-cycle lookup", int'(rsp_hit_o), 0);
    look(mk(7, 3), 0, "R9");
    look(mk(11, 2), 0, "R9");
    // idle cycle: R2 no response without request
    cyc(0, '0, 0, 0, 0, '0, 0, "R2");
    // random traffic on a few crowded sets
    for (int k = 0; k < 4000; k++) begin
      int idxs [4] = '{0, 1, 2, 127};
      logic [ADDR_W-1:0] la, fa;
      la = mk($urandom_range(0, 6), idxs[$urandom_range(0, 3)]);
      fa = mk($urandom_range(0, 6), idxs[$urandom_range(0, 3)]);
      cyc($urandom_range(0, 3) != 0, la, $urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 1), fa, $urandom_range(0, 199) == 0, "R7");
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule